// File: doc/BRIEF.md
# Receive/Transmit Interrupt Coalescer

This block sits between a network controller's per-frame completion pulses and its interrupt request flags. It merges bursts of receive and transmit completions into fewer interrupts. Each direction has its own window. The window opens on the first completion seen while that direction's interrupt flag is low. It closes, raising the flag, when a programmed number of completions has arrived or a programmed time has passed, whichever happens first.

A single 32-bit control word configures both directions. Bit 31 selects the tick rate: a fast tick of `FAST_DIV` clocks or a slow tick of `SLOW_DIV` clocks (defaults 2 and 4). Bits 30:27 give the transmit time limit in units of 16 ticks, and bits 26:24 the transmit completion limit. Bits 23:20 give the receive time limit in units of one tick, and bits 19:17 the receive completion limit. Bit 16 enables repeat mode. An all-zero word turns coalescing off, so that every completion interrupts at once. An interrupt flag stays high until software acknowledges it.

Top module: `irq_coalescer`

## Requirements
- R1: After reset both interrupt flags are low and the control word reads back as zero.
- R2: A write stores bits 31:16 of the written word, and from the next cycle on the read-back returns them with bits 15:0 forced to zero.
- R3: When a direction's time limit and completion limit are both zero, a completion that arrives while its flag is low raises that flag at the same clock edge.
- R4: With a nonzero completion limit P, the flag rises at the edge that samples the P-th completion of the window, counting the completion that opened it.
- R5: With a nonzero receive time limit T, the receive flag rises T×D edges after the edge that opened the window, where D is the tick length in clocks.
- R6: The transmit time limit counts in units of 16 ticks, so the flag rises T×16×D edges after the window opens.
- R7: Bit 31 = 0 gives a tick of FAST_DIV clocks (2 by default); bit 31 = 1 gives a tick of SLOW_DIV clocks (4 by default).
- R8: A completion limit of zero leaves the time limit as the only way to end a window, however many completions arrive.
- R9: With bit 16 = 0, a direction coalesces for one window only and then behaves as in R3 until the control word is written again.
- R10: With bit 16 = 1, every window opened after an acknowledge is coalesced again with the same limits.
- R11: A raised flag stays high until its acknowledge input is sampled, clears at that edge, and completions that arrive while it is high start no window.
- R12: The receive and transmit directions run independently, each with its own window, counter and flag.
- R13: A write to the control word discards any open window without raising its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_data | input | 32 | Control word write value |
| rx_done | input | 1 | Receive completion pulse |
| tx_done | input | 1 | Transmit completion pulse |
| rx_ack | input | 1 | Acknowledge of the receive flag |
| tx_ack | input | 1 | Acknowledge of the transmit flag |
| cfg_rd_data | output | 32 | Control word read-back |
| rx_irq | output | 1 | Coalesced receive interrupt flag |
| tx_irq | output | 1 | Coalesced transmit interrupt flag |

## Verification
The bench measures the delay from the opening completion to the flag for both tick rates and both time units. A wrong prescaler or unit shift would give a delay off by a factor, and an off-by-one in the tick counter would give a delay one tick early or late. It sends long trains of completions with a zero completion limit, sends completions while a flag is pending, and writes the control word while a window is open. A design that let completions end a window, reopened a window from a pending flag, or kept a stale window alive would raise a flag the model does not expect. It checks that the one-shot mode falls back to immediate interrupts and that a rewrite restores coalescing.

// File: rtl/icoal_pkg.sv
// Shared field positions and types of the interrupt coalescer.
package icoal_pkg;
    localparam int TMR_W     = 4;
    localparam int PKT_W     = 3;
    localparam int CFG_W     = 32;
    localparam int BIT_SLOW  = 31;
    localparam int TX_TMR_LO = 27;
    localparam int TX_PKT_LO = 24;
    localparam int RX_TMR_LO = 20;
    localparam int RX_PKT_LO = 17;
    localparam int BIT_CONT  = 16;
    localparam int KEEP_LO   = 16;

    typedef struct packed {
        logic [TMR_W-1:0] tmr;
        logic [PKT_W-1:0] pkt;
    } dir_cfg_t;
endpackage

// File: rtl/icoal_tick_gen.sv
// Tick prescaler for one direction.
// It emits a one-cycle tick every FAST_DIV or SLOW_DIV clocks while run is
// high, and it restarts its phase on restart.
// Assumes FAST_DIV and SLOW_DIV are both at least 1.
module icoal_tick_gen #(
    parameter int FAST_DIV = 2,
    parameter int SLOW_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    input  logic slow_sel,
    output logic tick
);
    localparam int MAX_DIV = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
    localparam int PRE_W   = ($clog2(MAX_DIV) > 0) ? $clog2(MAX_DIV) : 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] last;
    logic             wrap;

    // Last phase value of the selected tick length.
    always_comb begin
        last = slow_sel ? PRE_W'(SLOW_DIV - 1) : PRE_W'(FAST_DIV - 1);
        wrap = (pre_q >= last);
        tick = run && !restart && wrap;
    end

    // Phase counter: cleared on restart, advances while running.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pre_q <= '0;
        end else if (run) begin
            pre_q <= wrap ? '0 : pre_q + PRE_W'(1);
        end
    end
endmodule

// File: rtl/icoal_cfg_reg.sv
// Control word storage of the coalescer.
// It keeps bits 31:16 of the last write, reads bits 15:0 as zero, and splits
// the word into per-direction fields.
module icoal_cfg_reg
    import icoal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] rd_data,
    output logic             slow_sel,
    output logic             cont_en,
    output dir_cfg_t         rx_cfg,
    output dir_cfg_t         tx_cfg
);
    logic [CFG_W-1:KEEP_LO] store_q;
    logic                   unused_low;

    assign unused_low = ^wr_data[KEEP_LO-1:0];

    // Holds the upper half of the control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
        end else if (wr_en) begin
            store_q <= wr_data[CFG_W-1:KEEP_LO];
        end
    end

    // Field decode and read-back.
    always_comb begin
        rd_data    = {store_q, {KEEP_LO{1'b0}}};
        slow_sel   = rd_data[BIT_SLOW];
        cont_en    = rd_data[BIT_CONT];
        rx_cfg.tmr = rd_data[RX_TMR_LO +: TMR_W];
        rx_cfg.pkt = rd_data[RX_PKT_LO +: PKT_W];
        tx_cfg.tmr = rd_data[TX_TMR_LO +: TMR_W];
        tx_cfg.pkt = rd_data[TX_PKT_LO +: PKT_W];
    end
endmodule

// File: rtl/icoal_channel.sv
// Coalescing window for one direction.
// The window opens on a completion seen while the flag is low and closes on
// the completion limit or the time limit. The time limit counts in units of
// 2**UNIT_SHIFT ticks. Both limits zero, or a spent one-shot, means the
// flag is raised at once. A config write closes the window.
module icoal_channel
    import icoal_pkg::*;
#(
    parameter int UNIT_SHIFT = 0,
    parameter int FAST_DIV   = 2,
    parameter int SLOW_DIV   = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cfg_wr,
    input  logic     slow_sel,
    input  logic     cont_en,
    input  dir_cfg_t cfg,
    input  logic     done,
    input  logic     ack,
    output logic     irq,
    output logic     win_open
);
    localparam int LIM_W = TMR_W + UNIT_SHIFT;

    logic             irq_q, open_q, spent_q;
    logic [PKT_W-1:0] cnt_q;
    logic [LIM_W-1:0] tcnt_q, lim;
    logic             bypass, start, pkt_hit, tmr_hit, fire, tick;

    icoal_tick_gen #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (start && !bypass),
        .run      (open_q),
        .slow_sel (slow_sel),
        .tick     (tick)
    );

    // Window open, limit hit and fire decisions.
    always_comb begin
        bypass  = spent_q || (cfg.tmr == '0 && cfg.pkt == '0);
        start   = done && !irq_q && !open_q && !cfg_wr;
        lim     = LIM_W'(cfg.tmr) << UNIT_SHIFT;
        pkt_hit = open_q ? (done && cfg.pkt != '0 && cnt_q == cfg.pkt - PKT_W'(1))
                         : (start && cfg.pkt == PKT_W'(1));
        tmr_hit = open_q && tick && cfg.tmr != '0 && tcnt_q == lim - LIM_W'(1);
        fire    = !cfg_wr && ((start && bypass) || (!bypass && (pkt_hit || tmr_hit)));
    end

    // Window state: opened by start, closed by fire or a config write.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_wr || fire) begin
            open_q <= 1'b0;
        end else if (start && !bypass) begin
            open_q <= 1'b1;
        end
    end

    // Completion counter of the current window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= PKT_W'(1);
        end else if (open_q && done) begin
            cnt_q <= cnt_q + PKT_W'(1);
        end
    end

    // Tick counter of the current window.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            tcnt_q <= '0;
        end else if (open_q && tick) begin
            tcnt_q <= tcnt_q + LIM_W'(1);
        end
    end

    // One-shot marker, cleared by any config write.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_wr) begin
            spent_q <= 1'b0;
        end else if (fire && !bypass && !cont_en) begin
            spent_q <= 1'b1;
        end
    end

    // Sticky interrupt flag, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (fire) begin
            irq_q <= 1'b1;
        end else if (ack) begin
            irq_q <= 1'b0;
        end
    end

    assign irq      = irq_q;
    assign win_open = open_q;
endmodule

// File: rtl/irq_coalescer.sv
// Receive/transmit interrupt coalescer top.
// One control word configures two independent windows: receive times in
// single ticks, transmit times in units of 16 ticks.
// Assumes completion and acknowledge inputs are synchronous to clk.
module irq_coalescer
    import icoal_pkg::*;
#(
    parameter int FAST_DIV      = 2,
    parameter int SLOW_DIV      = 4,
    parameter int RX_UNIT_SHIFT = 0,
    parameter int TX_UNIT_SHIFT = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr_en,
    input  logic [31:0] cfg_wr_data,
    input  logic        rx_done,
    input  logic        tx_done,
    input  logic        rx_ack,
    input  logic        tx_ack,
    output logic [31:0] cfg_rd_data,
    output logic        rx_irq,
    output logic        tx_irq
);
    localparam int NUM_DIR = 2;

    logic                  slow_sel, cont_en;
    dir_cfg_t              rx_cfg, tx_cfg;
    dir_cfg_t [NUM_DIR-1:0] ch_cfg;
    logic [NUM_DIR-1:0]    ch_done, ch_ack, ch_irq, ch_open;
    logic                  rx_open, tx_open;

    icoal_cfg_reg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .wr_data  (cfg_wr_data),
        .rd_data  (cfg_rd_data),
        .slow_sel (slow_sel),
        .cont_en  (cont_en),
        .rx_cfg   (rx_cfg),
        .tx_cfg   (tx_cfg)
    );

    assign ch_cfg  = {tx_cfg, rx_cfg};
    assign ch_done = {tx_done, rx_done};
    assign ch_ack  = {tx_ack, rx_ack};

    for (genvar g = 0; g < NUM_DIR; g++) begin : g_ch
        localparam int SH = (g == 0) ? RX_UNIT_SHIFT : TX_UNIT_SHIFT;
        icoal_channel #(.UNIT_SHIFT(SH), .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_wr   (cfg_wr_en),
            .slow_sel (slow_sel),
            .cont_en  (cont_en),
            .cfg      (ch_cfg[g]),
            .done     (ch_done[g]),
            .ack      (ch_ack[g]),
            .irq      (ch_irq[g]),
            .win_open (ch_open[g])
        );
    end

    assign rx_irq  = ch_irq[0];
    assign tx_irq  = ch_irq[1];
    assign rx_open = ch_open[0];
    assign tx_open = ch_open[1];
endmodule

// File: rtl/icoal_checker.sv
// Protocol checks on the coalescer ports and window flags; bound to the top.
module icoal_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr_en,
    input logic [31:0] cfg_wr_data,
    input logic [31:0] cfg_rd_data,
    input logic        rx_done,
    input logic        tx_done,
    input logic        rx_ack,
    input logic        tx_ack,
    input logic        rx_irq,
    input logic        tx_irq,
    input logic        rx_open,
    input logic        tx_open
);
    AST_CFG_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_data[15:0] == 16'h0); // R2
    AST_CFG_WRITE_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |=> cfg_rd_data[31:16] == $past(cfg_wr_data[31:16])); // R2
    AST_RX_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_data == 32'h0 && rx_done && !rx_irq && !cfg_wr_en) |=> rx_irq); // R3
    AST_TX_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_data == 32'h0 && tx_done && !tx_irq && !cfg_wr_en) |=> tx_irq); // R3
    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && !rx_ack) |=> rx_irq); // R11
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && !tx_ack) |=> tx_irq); // R11
    AST_RX_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && rx_ack) |=> !rx_irq); // R11
    AST_TX_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && tx_ack) |=> !tx_irq); // R11
    AST_RX_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> ($past(rx_done) || $past(rx_open))); // R12
    AST_TX_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_irq) |-> ($past(tx_done) || $past(tx_open))); // R12
    AST_WRITE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |=> (!rx_open && !tx_open)); // R13
    AST_NO_OPEN_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_irq && rx_open) && !(tx_irq && tx_open)); // R11
endmodule

bind irq_coalescer icoal_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .cfg_rd_data (cfg_rd_data),
    .rx_done     (rx_done),
    .tx_done     (tx_done),
    .rx_ack      (rx_ack),
    .tx_ack      (tx_ack),
    .rx_irq      (rx_irq),
    .tx_irq      (tx_irq),
    .rx_open     (rx_open),
    .tx_open     (tx_open)
);

// File: tb/irq_coalescer_tb.sv
`timescale 1ns/1ps
module irq_coalescer_tb;
    localparam int FAST = 2;
    localparam int SLOW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic        rx_done = 1'b0, tx_done = 1'b0, rx_ack = 1'b0, tx_ack = 1'b0;
    logic [31:0] cfg_rd_data;
    logic        rx_irq, tx_irq;

    int checks = 0;
    int failures = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    irq_coalescer u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .rx_done(rx_done), .tx_done(tx_done), .rx_ack(rx_ack), .tx_ack(tx_ack),
        .cfg_rd_data(cfg_rd_data), .rx_irq(rx_irq), .tx_irq(tx_irq)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: per direction a flag, a window with a deadline
    // in absolute edge numbers, a completion count and a one-shot marker.
    int          m_irq[2], m_open[2], m_cnt[2], m_spent[2];
    longint      m_dl[2];
    longint      cyc = 0;
    logic [31:0] m_cfg = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < 2; d++) begin
                m_irq[d] = 0; m_open[d] = 0; m_cnt[d] = 0; m_spent[d] = 0; m_dl[d] = 0;
            end
            m_cfg = '0;
            cyc = 0;
        end else begin
            for (int d = 0; d < 2; d++) begin
                int t, p, unit, dv, fire, byp;
                bit dn, ak;
                t    = (d == 1) ? int'(m_cfg[30:27]) : int'(m_cfg[23:20]);
                p    = (d == 1) ? int'(m_cfg[26:24]) : int'(m_cfg[19:17]);
                unit = (d == 1) ? 16 : 1;
                dv   = m_cfg[31] ? SLOW : FAST;
                dn   = (d == 1) ? tx_done : rx_done;
                ak   = (d == 1) ? tx_ack : rx_ack;
                fire = 0;
                byp  = (m_spent[d] != 0) || (t == 0 && p == 0);
                if (cfg_wr_en) begin
                    m_open[d] = 0;
                    m_spent[d] = 0;
                end else if (m_open[d] != 0) begin
                    if (dn) m_cnt[d]++;
                    if (p != 0 && dn && m_cnt[d] == p) fire = 1;
                    if (t != 0 && cyc == m_dl[d]) fire = 1;
                end else if (dn && m_irq[d] == 0) begin
                    if (byp) fire = 1;
                    else begin
                        m_open[d] = 1;
                        m_cnt[d] = 1;
                        m_dl[d] = cyc + longint'(t * unit * dv);
                        if (p == 1) fire = 1;
                    end
                end
                if (fire != 0) begin
                    if (!byp && !m_cfg[16]) m_spent[d] = 1;
                    m_open[d] = 0;
                    m_irq[d] = 1;
                end else if (ak) begin
                    m_irq[d] = 0;
                end
            end
            if (cfg_wr_en) m_cfg = {cfg_wr_data[31:16], 16'h0};
            cyc++;
        end
    end

    // Every-cycle comparison against the reference (R12 covers both directions).
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            chk(rx_irq == m_irq[0][0], "R12 model rx_irq", longint'(rx_irq), longint'(m_irq[0]));
            chk(tx_irq == m_irq[1][0], "R12 model tx_irq", longint'(tx_irq), longint'(m_irq[1]));
            chk(cfg_rd_data == m_cfg, "R2 model cfg", longint'(cfg_rd_data), longint'(m_cfg));
        end
    end

    task automatic write_cfg(input logic [31:0] v);
        cfg_wr_en = 1'b1; cfg_wr_data = v;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic ack_rx();
        rx_ack = 1'b1; @(negedge clk); rx_ack = 1'b0;
    endtask

    task automatic ack_tx();
        tx_ack = 1'b1; @(negedge clk); tx_ack = 1'b0;
    endtask

    task automatic lat_rx(output int k);
        rx_done = 1'b1; k = 0;
        do begin @(negedge clk); k++; rx_done = 1'b0; end while (!rx_irq && k < 3000);
    endtask

    task automatic lat_tx(output int k);
        tx_done = 1'b1; k = 0;
        do begin @(negedge clk); k++; tx_done = 1'b0; end while (!tx_irq && k < 3000);
    endtask

    function automatic logic [31:0] mk(bit slow, int txt, int txp, int rxt, int rxp, bit cont);
        return (32'(slow) << 31) | (32'(txt) << 27) | (32'(txp) << 24) |
               (32'(rxt) << 20) | (32'(rxp) << 17) | (32'(cont) << 16);
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int k, kr, kt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!rx_irq && !tx_irq, "R1 flags after reset", longint'({rx_irq, tx_irq}), 0);
        chk(cfg_rd_data == 0, "R1 cfg after reset", longint'(cfg_rd_data), 0);

        // R2: upper half kept, lower half reads zero
        write_cfg(32'hFFFF_FFFF);
        chk(cfg_rd_data == 32'hFFFF_0000, "R2 readback all ones", longint'(cfg_rd_data), 32'hFFFF_0000);
        write_cfg(32'h8015_0000);
        chk(cfg_rd_data == 32'h8015_0000, "R2 readback sample", longint'(cfg_rd_data), 32'h8015_0000);

        // R3: all-zero word gives immediate interrupts
        write_cfg(32'h0);
        lat_rx(k); chk(k == 1, "R3 rx immediate", k, 1);
        lat_tx(k); chk(k == 1, "R3 tx immediate", k, 1);
        ack_rx(); ack_tx();
        chk(!rx_irq && !tx_irq, "R11 ack clears", longint'({rx_irq, tx_irq}), 0);

        // R4: completion limit 3 ends the window at the third completion
        write_cfg(mk(0, 0, 0, 15, 3, 1));
        rx_done = 1'b1; @(negedge clk); @(negedge clk);
        chk(!rx_irq, "R4 not before limit", rx_irq, 0);
        @(negedge clk); rx_done = 1'b0;
        chk(rx_irq, "R4 at limit", rx_irq, 1);
        ack_rx();

        // R5: receive time limit 3 with fast tick
        write_cfg(mk(0, 0, 0, 3, 0, 1));
        lat_rx(k); chk(k == 3 * FAST + 1, "R5 rx timer fast", k, 3 * FAST + 1);
        ack_rx();

        // R7: slow tick doubles the delay
        write_cfg(mk(1, 0, 0, 3, 0, 1));
        lat_rx(k); chk(k == 3 * SLOW + 1, "R7 rx timer slow", k, 3 * SLOW + 1);
        ack_rx();

        // R6: transmit time limit counts 16 ticks per unit
        write_cfg(mk(0, 2, 0, 0, 0, 1));
        lat_tx(k); chk(k == 2 * 16 * FAST + 1, "R6 tx timer fast", k, 2 * 16 * FAST + 1);
        ack_tx();
        write_cfg(mk(1, 1, 0, 0, 0, 1));
        lat_tx(k); chk(k == 16 * SLOW + 1, "R7 tx timer slow", k, 16 * SLOW + 1);
        ack_tx();

        // R8: zero completion limit, many completions, only the timer ends it
        write_cfg(mk(0, 0, 0, 4, 0, 1));
        rx_done = 1'b1; k = 0;
        repeat (6) begin @(negedge clk); k++; end
        rx_done = 1'b0;
        chk(!rx_irq, "R8 completions do not end window", rx_irq, 0);
        while (!rx_irq && k < 3000) begin @(negedge clk); k++; end
        chk(k == 4 * FAST + 1, "R8 timer ends window", k, 4 * FAST + 1);
        ack_rx();

        // R9: one-shot mode falls back to immediate, rewrite restores
        write_cfg(mk(0, 0, 0, 2, 0, 0));
        lat_rx(k); chk(k == 2 * FAST + 1, "R9 first window", k, 2 * FAST + 1);
        ack_rx();
        lat_rx(k); chk(k == 1, "R9 spent is immediate", k, 1);
        ack_rx();
        write_cfg(mk(0, 0, 0, 2, 0, 0));
        lat_rx(k); chk(k == 2 * FAST + 1, "R9 rewrite restores", k, 2 * FAST + 1);
        ack_rx();

        // R10: repeat mode coalesces every window
        write_cfg(mk(0, 0, 0, 2, 0, 1));
        lat_rx(k); chk(k == 2 * FAST + 1, "R10 window one", k, 2 * FAST + 1);
        ack_rx();
        lat_rx(k); chk(k == 2 * FAST + 1, "R10 window two", k, 2 * FAST + 1);

        // R11: flag held without ack; completions while high start nothing
        repeat (5) @(negedge clk);
        chk(rx_irq, "R11 flag held", rx_irq, 1);
        rx_done = 1'b1; @(negedge clk); @(negedge clk); rx_done = 1'b0;
        ack_rx();
        repeat (12) @(negedge clk);
        chk(!rx_irq, "R11 ignored completions", rx_irq, 0);

        // R12: both directions at once with different limits
        write_cfg(mk(0, 1, 0, 3, 0, 1));
        rx_done = 1'b1; tx_done = 1'b1; k = 0; kr = 0; kt = 0;
        while ((kr == 0 || kt == 0) && k < 3000) begin
            @(negedge clk); k++; rx_done = 1'b0; tx_done = 1'b0;
            if (rx_irq && kr == 0) kr = k;
            if (tx_irq && kt == 0) kt = k;
        end
        chk(kr == 3 * FAST + 1, "R12 rx independent", kr, 3 * FAST + 1);
        chk(kt == 16 * FAST + 1, "R12 tx independent", kt, 16 * FAST + 1);
        ack_rx(); ack_tx();

        // R13: a write discards an open window
        write_cfg(mk(0, 0, 0, 5, 0, 1));
        rx_done = 1'b1; @(negedge clk); rx_done = 1'b0;
        repeat (3) @(negedge clk);
        write_cfg(mk(0, 0, 0, 5, 0, 1));
        repeat (20) @(negedge clk);
        chk(!rx_irq, "R13 window discarded", rx_irq, 0);

        repeat (4) @(negedge clk);
        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule